// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-thread mask of one warp consistent while the warp runs through divergent branches. A split operation looks at a per-thread predicate vector together with the current thread mask. If every active thread agrees, the block records a single uniform marker and the mask stays the same. If they disagree, the block saves the current mask, then saves the set of predicate-true threads with the split PC, and continues with only the predicate-false threads active.

A join operation pops the top record. A uniform marker only restores its mask. A saved predicate record restores the predicate-true threads and asks the fetch stage to jump back to the stored PC for one cycle. A saved full mask restores the whole mask and lets execution fall through. The split and join strobes may stay high for several cycles while one instruction is applied to many threads. The block acts only on the first cycle of each strobe.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset `nextMask` is 1 (thread 0 only), `stackEmpty` is 1, `stackFull` is 0, `pcRedirValid` is 0 and `stackErr` is 0.
- R2: A split counts as uniform when `predVec & curMask` is zero or equals `curMask`. It pushes one record and loads `nextMask` with `curMask` one cycle later.
- R3: A non-uniform split pushes two records: first `curMask`, then `predVec & curMask` with `pcIn`. One cycle later `nextMask` equals `curMask & ~predVec`.
- R4: A join whose top record is a uniform marker pops it and restores its mask. `pcRedirValid` stays 0.
- R5: A join whose top record is a predicate record pops it, restores its mask, and raises `pcRedirValid` with `pcRedirAddr` equal to that split's `pcIn`.
- R6: A join whose top record is a saved full mask pops it and restores the mask with no redirect.
- R7: Each strobe acts only on the cycle it rises. A strobe held high for several cycles counts as one operation.
- R8: `stackFull` is 1 exactly when the stack holds DEPTH records. `stackEmpty` is 1 exactly when it holds none.
- R9: A split without room for its records (one for a uniform split, two for a non-uniform split) sets `stackErr`. The stack and `nextMask` stay unchanged.
- R10: A join on an empty stack sets `stackErr` and changes neither the stack nor `nextMask`. `stackErr` stays 1 until reset.
- R11: When split and join rise in the same cycle, only the split is performed.
- R12: `pcRedirValid` is high for exactly one cycle, and only in the cycle after a join that pops a predicate record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| splitStb | input | 1 | Split request, acted on at its rising cycle |
| joinStb | input | 1 | Join request, acted on at its rising cycle |
| predVec | input | THREADS | Per-thread predicate bits |
| curMask | input | THREADS | Current active-thread mask |
| pcIn | input | PC_W | PC of the split instruction |
| nextMask | output | THREADS | Registered active-thread mask |
| pcRedirValid | output | 1 | One-cycle request to jump back |
| pcRedirAddr | output | PC_W | Target of the jump request |
| stackFull | output | 1 | Stack holds DEPTH records |
| stackEmpty | output | 1 | Stack holds no records |
| stackErr | output | 1 | Sticky overflow/underflow flag |

## Verification
A wrong record kind or a wrong pointer does not show at the ports when the record is written. It shows only at the join that pops it: a missing or spurious `pcRedirValid`, or a wrong mask, one cycle after that join. For this reason the bench ends every nested sequence with enough joins to drain the stack completely. It then checks `stackEmpty` at exactly the last join, so a pointer that is off by one makes the flag appear one join early or one join late. Overflow and underflow cases check `nextMask` and the number of joins needed to drain the stack, which confirms that a refused operation left no trace.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  typedef enum logic [1:0] {
    KIND_UNI    = 2'd0,
    KIND_RESUME = 2'd1,
    KIND_BRANCH = 2'd2
  } recKind_t;

  typedef struct packed {
    logic pushUni;
    logic pushDiv;
    logic pop;
  } stackCmd_t;

endpackage

// File: rtl/simt_stack_ctrl.sv
module simt_stack_ctrl
  import simt_stack_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               splitStb,
  input  logic               joinStb,
  input  logic [THREADS-1:0] predVec,
  input  logic [THREADS-1:0] curMask,
  input  logic [CNT_W-1:0]   depthCnt,
  output stackCmd_t          cmd,
  output logic               errFlag
);

  logic splitQ, joinQ;
  logic splitFire, joinFire;
  logic [THREADS-1:0] activePred;
  logic isUni, roomOne, roomTwo, splitOk, notEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitQ  <= 1'b0;
      joinQ   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      splitQ <= splitStb;
      joinQ  <= joinStb;
      if ((splitFire && !splitOk) || (joinFire && !notEmpty))
        errFlag <= 1'b1;
    end
  end

  always_comb begin
    splitFire  = splitStb && !splitQ;
    joinFire   = joinStb && !joinQ && !splitFire;
    activePred = predVec & curMask;
    isUni      = (activePred == '0) || (activePred == curMask);
    roomOne    = (int'(depthCnt) + 1) <= DEPTH;
    roomTwo    = (int'(depthCnt) + 2) <= DEPTH;
    splitOk    = isUni ? roomOne : roomTwo;
    notEmpty   = (depthCnt != '0);
    cmd.pushUni = splitFire && isUni && splitOk;
    cmd.pushDiv = splitFire && !isUni && splitOk;
    cmd.pop     = joinFire && notEmpty;
  end

  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> (depthCnt != '0));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_split_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pushUni || cmd.pushDiv) |-> !cmd.pop);

  p_held_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    (splitStb && $past(splitStb)) |-> !(cmd.pushUni || cmd.pushDiv));

endmodule

// File: rtl/simt_stack_data.sv
module simt_stack_data
  import simt_stack_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCmd_t          cmd,
  input  logic [THREADS-1:0] predVec,
  input  logic [THREADS-1:0] curMask,
  input  logic [PC_W-1:0]    pcIn,
  output logic [CNT_W-1:0]   depthCnt,
  output logic [THREADS-1:0] nextMask,
  output logic               pcRedirValid,
  output logic [PC_W-1:0]    pcRedirAddr
);

  logic [THREADS-1:0] branchMask;
  logic [THREADS-1:0] maskArr [DEPTH];
  logic [PC_W-1:0]    pcArr   [DEPTH];
  recKind_t           kindArr [DEPTH];
  logic [THREADS-1:0] topMask;
  logic [PC_W-1:0]    topPc;
  recKind_t           topKind;
  logic [CNT_W-1:0]   topIdx;

  assign branchMask = predVec & curMask;
  assign topIdx     = depthCnt - CNT_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [THREADS-1:0] slotMask;
    logic [PC_W-1:0]    slotPc;
    recKind_t           slotKind;
    logic hitLow, hitHigh;

    assign hitLow  = (CNT_W'(g) == depthCnt);
    assign hitHigh = (CNT_W'(g) == depthCnt + CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotMask <= '0;
        slotPc   <= '0;
        slotKind <= KIND_UNI;
      end else if (cmd.pushUni && hitLow) begin
        slotMask <= curMask;
        slotPc   <= pcIn;
        slotKind <= KIND_UNI;
      end else if (cmd.pushDiv && hitLow) begin
        slotMask <= curMask;
        slotPc   <= pcIn;
        slotKind <= KIND_RESUME;
      end else if (cmd.pushDiv && hitHigh) begin
        slotMask <= branchMask;
        slotPc   <= pcIn;
        slotKind <= KIND_BRANCH;
      end
    end

    assign maskArr[g] = slotMask;
    assign pcArr[g]   = slotPc;
    assign kindArr[g] = slotKind;
  end

  always_comb begin
    topMask = '0;
    topPc   = '0;
    topKind = KIND_UNI;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) == topIdx) begin
        topMask = maskArr[i];
        topPc   = pcArr[i];
        topKind = kindArr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthCnt     <= '0;
      nextMask     <= THREADS'(1);
      pcRedirValid <= 1'b0;
      pcRedirAddr  <= '0;
    end else begin
      pcRedirValid <= 1'b0;
      if (cmd.pushUni) begin
        depthCnt <= depthCnt + CNT_W'(1);
        nextMask <= curMask;
      end else if (cmd.pushDiv) begin
        depthCnt <= depthCnt + CNT_W'(2);
        nextMask <= curMask & ~branchMask;
      end else if (cmd.pop) begin
        depthCnt <= topIdx;
        nextMask <= topMask;
        if (topKind == KIND_BRANCH) begin
          pcRedirValid <= 1'b1;
          pcRedirAddr  <= topPc;
        end
      end
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    int'(depthCnt) <= DEPTH);

  p_uni_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pushUni |=> depthCnt == $past(depthCnt) + CNT_W'(1));

  p_div_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pushDiv |=> (nextMask & $past(branchMask)) == '0);

  p_redir_after_pop_r12: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirValid |-> $past(cmd.pop));

  p_redir_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pcRedirValid && !cmd.pop) |=> !pcRedirValid);

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_stack_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               splitStb,
  input  logic               joinStb,
  input  logic [THREADS-1:0] predVec,
  input  logic [THREADS-1:0] curMask,
  input  logic [PC_W-1:0]    pcIn,
  output logic [THREADS-1:0] nextMask,
  output logic               pcRedirValid,
  output logic [PC_W-1:0]    pcRedirAddr,
  output logic               stackFull,
  output logic               stackEmpty,
  output logic               stackErr
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  stackCmd_t        cmd;
  logic [CNT_W-1:0] depthCnt;

  simt_stack_ctrl #(.THREADS(THREADS), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .splitStb(splitStb), .joinStb(joinStb),
    .predVec(predVec), .curMask(curMask), .depthCnt(depthCnt),
    .cmd(cmd), .errFlag(stackErr)
  );

  simt_stack_data #(.THREADS(THREADS), .DEPTH(DEPTH), .PC_W(PC_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .predVec(predVec), .curMask(curMask),
    .pcIn(pcIn), .depthCnt(depthCnt), .nextMask(nextMask),
    .pcRedirValid(pcRedirValid), .pcRedirAddr(pcRedirAddr)
  );

  assign stackFull  = (int'(depthCnt) == DEPTH);
  assign stackEmpty = (depthCnt == '0);

endmodule

// File: tb/sim_simt_mask_stack.sv
`timescale 1ns/1ps
module sim_simt_mask_stack;

  localparam int NT = 4;
  localparam int ND = 8;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic splitStb = 1'b0, joinStb = 1'b0;
  logic [NT-1:0] predVec = '0, curMask = '0;
  logic [PW-1:0] pcIn = '0;
  logic [NT-1:0] nextMask;
  logic pcRedirValid, stackFull, stackEmpty, stackErr;
  logic [PW-1:0] pcRedirAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simt_mask_stack #(.THREADS(NT), .DEPTH(ND), .PC_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .splitStb(splitStb), .joinStb(joinStb),
    .predVec(predVec), .curMask(curMask), .pcIn(pcIn),
    .nextMask(nextMask), .pcRedirValid(pcRedirValid), .pcRedirAddr(pcRedirAddr),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .stackErr(stackErr)
  );

  typedef struct packed {
    logic          sp;
    logic          jn;
    logic [3:0]    pred;
    logic [3:0]    cur;
    logic [31:0]   pc;
    logic [3:0]    eMask;
    logic          eRedir;
    logic [31:0]   eAddr;
    logic          eEmpty;
  } vec_t;

  // Nested split/join sequences covering R2..R6 and R12
  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b0, 4'hF, 4'hF, 32'd100, 4'hF, 1'b0, 32'd0,   1'b0},
    '{1'b1, 1'b0, 4'h3, 4'hF, 32'd200, 4'hC, 1'b0, 32'd0,   1'b0},
    '{1'b1, 1'b0, 4'h0, 4'hC, 32'd250, 4'hC, 1'b0, 32'd0,   1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'hC, 1'b0, 32'd0,   1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'h3, 1'b1, 32'd200, 1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'hF, 1'b0, 32'd0,   1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'hF, 1'b0, 32'd0,   1'b1},
    '{1'b1, 1'b0, 4'h4, 4'h5, 32'd300, 4'h1, 1'b0, 32'd0,   1'b0},
    '{1'b1, 1'b0, 4'h1, 4'h1, 32'd310, 4'h1, 1'b0, 32'd0,   1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'h1, 1'b0, 32'd0,   1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'h4, 1'b1, 32'd300, 1'b0},
    '{1'b0, 1'b1, 4'h0, 4'h0, 32'd0,   4'h5, 1'b0, 32'd0,   1'b1}
  };

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One-cycle strobe; returns at the negedge after the acting edge
  task automatic pulse(input logic sp, input logic jn, input logic [3:0] pr,
                       input logic [3:0] cu, input logic [31:0] pc);
    @(negedge clk);
    splitStb = sp; joinStb = jn; predVec = pr; curMask = cu; pcIn = pc;
    @(negedge clk);
    splitStb = 1'b0; joinStb = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    doReset();
    // R1 reset state
    checkEq("R1 mask", 32'(nextMask), 32'h1);
    checkEq("R1 empty", 32'(stackEmpty), 32'h1);
    checkEq("R1 full", 32'(stackFull), 32'h0);
    checkEq("R1 redir", 32'(pcRedirValid), 32'h0);
    checkEq("R1 err", 32'(stackErr), 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      pulse(VECS[i].sp, VECS[i].jn, VECS[i].pred, VECS[i].cur, VECS[i].pc);
      checkEq($sformatf("R2-6 vec%0d mask", i), 32'(nextMask), 32'(VECS[i].eMask));
      checkEq($sformatf("R5 vec%0d redir", i), 32'(pcRedirValid), 32'(VECS[i].eRedir));
      if (VECS[i].eRedir)
        checkEq($sformatf("R5 vec%0d addr", i), pcRedirAddr, VECS[i].eAddr);
      checkEq($sformatf("R8 vec%0d empty", i), 32'(stackEmpty), 32'(VECS[i].eEmpty));
      if (i == 4) begin
        @(negedge clk);
        checkEq("R12 redirect one cycle", 32'(pcRedirValid), 32'h0);
      end
    end
    checkEq("R9 no error after table", 32'(stackErr), 32'h0);

    // R7: split held three cycles acts once
    @(negedge clk);
    splitStb = 1'b1; predVec = 4'h1; curMask = 4'hF; pcIn = 32'd400;
    repeat (3) @(negedge clk);
    splitStb = 1'b0;
    checkEq("R7 held split mask", 32'(nextMask), 32'hE);
    pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R7 first join redir addr", pcRedirAddr, 32'd400);
    pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R7 drained after two joins", 32'(stackEmpty), 32'h1);

    // R11: split and join rise together, split wins
    pulse(1'b1, 1'b1, 4'hF, 4'hF, 32'd500);
    checkEq("R11 split taken", 32'(stackEmpty), 32'h0);
    checkEq("R11 no error", 32'(stackErr), 32'h0);
    pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R11 one record", 32'(stackEmpty), 32'h1);

    // R8 / R9: fill, then overflow with a uniform split
    for (int k = 0; k < ND; k++) pulse(1'b1, 1'b0, 4'hF, 4'hF, 32'd600);
    checkEq("R8 full", 32'(stackFull), 32'h1);
    pulse(1'b1, 1'b0, 4'h0, 4'h3, 32'd700);
    checkEq("R9 err on overflow", 32'(stackErr), 32'h1);
    checkEq("R9 mask kept", 32'(nextMask), 32'hF);
    for (int k = 0; k < ND - 1; k++) pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R9 not yet empty", 32'(stackEmpty), 32'h0);
    pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R9 stack unchanged by overflow", 32'(stackEmpty), 32'h1);

    // R9: divergent split with a single free slot
    doReset();
    for (int k = 0; k < ND - 1; k++) pulse(1'b1, 1'b0, 4'hF, 4'hF, 32'd800);
    pulse(1'b1, 1'b0, 4'h1, 4'hF, 32'd810);
    checkEq("R9 div err", 32'(stackErr), 32'h1);
    checkEq("R9 div mask kept", 32'(nextMask), 32'hF);
    checkEq("R9 div not full", 32'(stackFull), 32'h0);
    for (int k = 0; k < ND - 1; k++) pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R9 div drained", 32'(stackEmpty), 32'h1);

    // R10: join on empty stack
    doReset();
    checkEq("R10 err cleared by reset", 32'(stackErr), 32'h0);
    pulse(1'b0, 1'b1, 4'h0, 4'h0, 32'd0);
    checkEq("R10 underflow err", 32'(stackErr), 32'h1);
    checkEq("R10 mask kept", 32'(nextMask), 32'h1);
    checkEq("R10 no redirect", 32'(pcRedirValid), 32'h0);
    repeat (3) @(negedge clk);
    checkEq("R10 err sticky", 32'(stackErr), 32'h1);

    finish();
  end

endmodule